// File: doc/BRIEF.md
# Interrupt input pending tracker

This block turns raw interrupt wires into per-CPU pending bits. One group of input lines carries shared interrupts, which every CPU sees. The other lines carry private interrupts, 32 for each CPU in consecutive groups. For every interrupt number the block keeps a latched input level, an enable bit, a pending bit and a trigger mode, which is either edge or level. Private interrupts keep a separate enable, level and pending bit for each CPU. Shared interrupts carry a CPU target mask.

Each input line passes through a two-stage synchroniser. The synchronised value is then compared with the stored level, and any difference counts as a rising or falling event in that cycle. A one-command-per-cycle port lets the neighbouring blocks do four things: enable or disable an interrupt, set its trigger mode or target mask, set or clear pending bits (as an acknowledge unit does), and report completion of an interrupt. A level-triggered interrupt whose input is still high becomes pending again when it is enabled or completed. Priority arbitration and CPU signalling are left to downstream logic, which reads the flat pending, enable and level vectors.

Top module: `irq_pend_tracker`

## Requirements
- R1: Input line k below N_SHARED drives shared interrupt k+32. Its stored level appears on lvl_o for every CPU. On a rise it sets pending only for the CPUs in the interrupt's target mask (cmd_arg_i bit c selects CPU c, written with op 4).
- R2: Input line k at or above N_SHARED drives private interrupt (k-N_SHARED) mod 32 of CPU (k-N_SHARED)/32. It touches only that CPU's level and pending bits. Enables of interrupts 0..31 are kept separately for each CPU.
- R3: When the synchronised input equals the stored level, nothing changes. In particular, a line held high does not set pending again after pending has been cleared.
- R4: On a rise, the stored level becomes 1. Pending is set for the targets when the interrupt is edge-triggered, or when it is level-triggered and enabled. The result is visible after the third rising clock edge that follows the input change.
- R5: On a fall, only the stored level is cleared. Pending bits stay as they were.
- R6: Enabling (op 1) a level-triggered interrupt whose stored level is high sets pending for its targets in the same update. For a private interrupt the target is the commanding CPU.
- R7: Completion (op 7) by CPU c sets pending for c again only when four conditions hold: the interrupt is level-triggered, it is enabled for c, its level is high, and c is among its targets. Otherwise completion changes nothing.
- R8: After reset: interrupts 0..15 are enabled for all CPUs and edge-triggered. All other enables, all pending bits, all levels and all target masks are 0, and interrupts 16 and up are level-triggered.
- R9: Op 5 sets pending and op 6 clears it. For a private interrupt, both act on the commanding CPU only. For a shared interrupt, set acts on the target mask and clear acts on all CPUs. Op 2 disables, and op 3 writes the trigger mode, where cmd_arg_i[0]=1 means edge.
- R10: A pending clear in the same cycle as a pending set caused by an input rise wins: the bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | N_SHARED+32*N_CPU | Raw interrupt wires: shared lines first, then 32 private lines per CPU |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (0 none, 1 enable, 2 disable, 3 trigger, 4 target, 5 set pending, 6 clear pending, 7 complete) |
| cmd_cpu_i | input | CPU_W | Commanding CPU |
| cmd_irq_i | input | IRQ_W | Interrupt number |
| cmd_arg_i | input | N_CPU | Target mask, or bit 0 as the trigger mode |
| pend_o | output | N_CPU*(N_SHARED+32) | Pending bits, index cpu*NIRQ+irq |
| en_o | output | N_CPU*(N_SHARED+32) | Enable bits as seen by each CPU |
| lvl_o | output | N_CPU*(N_SHARED+32) | Stored input level as seen by each CPU |

## Verification
The bench checks how line indices map to CPUs and interrupt numbers. A wrong division would raise the right interrupt on the wrong CPU, or on every CPU. It also checks that a level input still high re-arms pending on enable and on completion, and that a completion from a CPU outside the target mask is refused. A design that confused trigger modes or ignored the target mask would leave a bit set or clear where it should not be. A pending clear is timed to land in exactly the cycle in which a synchronised rise sets the same bit, so that a design giving the set priority is exposed. The bench also confirms that a falling edge, or a line held high, leaves pending untouched.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int PRIV_PER_CPU = 32;
    localparam int EDGE_AT_RESET = 16;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_EN_SET   = 3'd1,
        OP_EN_CLR   = 3'd2,
        OP_TRIG     = 3'd3,
        OP_TGT      = 3'd4,
        OP_PEND_SET = 3'd5,
        OP_PEND_CLR = 3'd6,
        OP_DONE     = 3'd7
    } cmd_op_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = raw_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign rise_o[k] = sync_i[k] & ~lvl_i[k];
        assign fall_o[k] = ~sync_i[k] & lvl_i[k];
    end
endmodule

// File: rtl/irq_state_core.sv
module irq_state_core
    import irq_pend_pkg::*;
#(
    parameter int N_SHARED = 32,
    parameter int N_CPU    = 2,
    localparam int NIRQ    = N_SHARED + PRIV_PER_CPU,
    localparam int NLINES  = N_SHARED + PRIV_PER_CPU * N_CPU,
    localparam int CPU_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int IRQ_W   = $clog2(NIRQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLINES-1:0]     rise_i,
    input  logic [NLINES-1:0]     fall_i,
    input  logic                  cmd_valid_i,
    input  logic [2:0]            cmd_op_i,
    input  logic [CPU_W-1:0]      cmd_cpu_i,
    input  logic [IRQ_W-1:0]      cmd_irq_i,
    input  logic [N_CPU-1:0]      cmd_arg_i,
    output logic [NLINES-1:0]     lvl_line_o,
    output logic [N_CPU*NIRQ-1:0] pend_o,
    output logic [N_CPU*NIRQ-1:0] en_o,
    output logic [N_CPU*NIRQ-1:0] lvl_o
);
    typedef struct packed {
        logic [NLINES-1:0]                lvl;
        logic [N_SHARED-1:0]              en_sh;
        logic [N_CPU*PRIV_PER_CPU-1:0]    en_pv;
        logic [NIRQ-1:0]                  trig;
        logic [N_SHARED*N_CPU-1:0]        tgt;
        logic [N_CPU*NIRQ-1:0]            pend;
    } state_t;

    state_t d, q;

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int i = 0; i < EDGE_AT_RESET; i++) begin
            r.trig[i] = 1'b1;
            for (int c = 0; c < N_CPU; c++) begin
                r.en_pv[c*PRIV_PER_CPU + i] = 1'b1;
            end
        end
        return r;
    endfunction

    always_comb begin
        int ci;
        int ii;
        int lidx;
        int sidx;
        logic priv;
        logic lvl_now;
        logic en_now;
        logic [N_CPU-1:0] tmask;

        d = q;
        ci = int'(cmd_cpu_i);
        ii = int'(cmd_irq_i);
        priv = (ii < PRIV_PER_CPU);
        sidx = 0;
        lidx = 0;
        lvl_now = 1'b0;
        en_now = 1'b0;
        tmask = '0;

        // Input events: level follows the synchronised line.
        for (int k = 0; k < NLINES; k++) begin
            if (rise_i[k]) d.lvl[k] = 1'b1;
            if (fall_i[k]) d.lvl[k] = 1'b0;
        end
        // Shared rises set pending in the target mask.
        for (int s = 0; s < N_SHARED; s++) begin
            if (rise_i[s] && (q.trig[PRIV_PER_CPU+s] || q.en_sh[s])) begin
                for (int c = 0; c < N_CPU; c++) begin
                    if (q.tgt[s*N_CPU + c]) d.pend[c*NIRQ + PRIV_PER_CPU + s] = 1'b1;
                end
            end
        end
        // Private rises touch only their own CPU.
        for (int c = 0; c < N_CPU; c++) begin
            for (int i = 0; i < PRIV_PER_CPU; i++) begin
                if (rise_i[N_SHARED + c*PRIV_PER_CPU + i]
                    && (q.trig[i] || q.en_pv[c*PRIV_PER_CPU + i])) begin
                    d.pend[c*NIRQ + i] = 1'b1;
                end
            end
        end

        // Commands act after input events, so a clear overrides a set.
        if (cmd_valid_i && ii < NIRQ && ci < N_CPU) begin
            sidx = priv ? 0 : ii - PRIV_PER_CPU;
            lidx = priv ? N_SHARED + ci*PRIV_PER_CPU + ii : sidx;
            lvl_now = d.lvl[lidx];
            en_now = priv ? q.en_pv[ci*PRIV_PER_CPU + ii] : q.en_sh[sidx];
            for (int c = 0; c < N_CPU; c++) begin
                tmask[c] = priv ? (c == ci) : q.tgt[sidx*N_CPU + c];
            end
            case (cmd_op_e'(cmd_op_i))
                OP_EN_SET: begin
                    if (priv) d.en_pv[ci*PRIV_PER_CPU + ii] = 1'b1;
                    else      d.en_sh[sidx] = 1'b1;
                    if (lvl_now && !q.trig[ii]) begin
                        for (int c = 0; c < N_CPU; c++) begin
                            if (tmask[c]) d.pend[c*NIRQ + ii] = 1'b1;
                        end
                    end
                end
                OP_EN_CLR: begin
                    if (priv) d.en_pv[ci*PRIV_PER_CPU + ii] = 1'b0;
                    else      d.en_sh[sidx] = 1'b0;
                end
                OP_TRIG: d.trig[ii] = cmd_arg_i[0];
                OP_TGT: begin
                    if (!priv) d.tgt[sidx*N_CPU +: N_CPU] = cmd_arg_i;
                end
                OP_PEND_SET: begin
                    for (int c = 0; c < N_CPU; c++) begin
                        if (tmask[c]) d.pend[c*NIRQ + ii] = 1'b1;
                    end
                end
                OP_PEND_CLR: begin
                    for (int c = 0; c < N_CPU; c++) begin
                        if (!priv || c == ci) d.pend[c*NIRQ + ii] = 1'b0;
                    end
                end
                OP_DONE: begin
                    if (!q.trig[ii] && en_now && lvl_now && tmask[ci]) begin
                        d.pend[ci*NIRQ + ii] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_state();
        else        q <= d;
    end

    assign lvl_line_o = q.lvl;
    assign pend_o     = q.pend;

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NIRQ; i++) begin : g_irq
            if (i < PRIV_PER_CPU) begin : g_priv
                assign en_o[c*NIRQ + i]  = q.en_pv[c*PRIV_PER_CPU + i];
                assign lvl_o[c*NIRQ + i] = q.lvl[N_SHARED + c*PRIV_PER_CPU + i];
            end else begin : g_shared
                assign en_o[c*NIRQ + i]  = q.en_sh[i - PRIV_PER_CPU];
                assign lvl_o[c*NIRQ + i] = q.lvl[i - PRIV_PER_CPU];
            end
        end
    end
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
    import irq_pend_pkg::*;
#(
    parameter int N_SHARED = 32,
    parameter int N_CPU    = 2,
    localparam int NIRQ    = N_SHARED + PRIV_PER_CPU,
    localparam int NLINES  = N_SHARED + PRIV_PER_CPU * N_CPU,
    localparam int CPU_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int IRQ_W   = $clog2(NIRQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLINES-1:0]     irq_lines_i,
    input  logic                  cmd_valid_i,
    input  logic [2:0]            cmd_op_i,
    input  logic [CPU_W-1:0]      cmd_cpu_i,
    input  logic [IRQ_W-1:0]      cmd_irq_i,
    input  logic [N_CPU-1:0]      cmd_arg_i,
    output logic [N_CPU*NIRQ-1:0] pend_o,
    output logic [N_CPU*NIRQ-1:0] en_o,
    output logic [N_CPU*NIRQ-1:0] lvl_o
);
    logic [NLINES-1:0] sync_w;
    logic [NLINES-1:0] lvl_line_w;
    logic [NLINES-1:0] rise_w;
    logic [NLINES-1:0] fall_w;

    irq_sync #(.W(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_lines_i),
        .sync_o (sync_w)
    );

    irq_edge_detect #(.W(NLINES)) u_edge (
        .sync_i (sync_w),
        .lvl_i  (lvl_line_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    irq_state_core #(.N_SHARED(N_SHARED), .N_CPU(N_CPU)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise_w),
        .fall_i      (fall_w),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_cpu_i   (cmd_cpu_i),
        .cmd_irq_i   (cmd_irq_i),
        .cmd_arg_i   (cmd_arg_i),
        .lvl_line_o  (lvl_line_w),
        .pend_o      (pend_o),
        .en_o        (en_o),
        .lvl_o       (lvl_o)
    );
endmodule

// File: rtl/irq_pend_tracker_chk.sv
module irq_pend_tracker_chk
    import irq_pend_pkg::*;
#(
    parameter int N_SHARED = 32,
    parameter int N_CPU    = 2,
    localparam int NIRQ    = N_SHARED + PRIV_PER_CPU,
    localparam int CPU_W   = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    localparam int IRQ_W   = $clog2(NIRQ)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid_i,
    input logic [2:0]            cmd_op_i,
    input logic [CPU_W-1:0]      cmd_cpu_i,
    input logic [IRQ_W-1:0]      cmd_irq_i,
    input logic [N_CPU*NIRQ-1:0] pend_o,
    input logic [N_CPU*NIRQ-1:0] en_o,
    input logic [N_CPU*NIRQ-1:0] lvl_o
);
    // R8: state right after reset release
    p_reset_state_r8: assert property (@(posedge clk)
        $rose(rst_n) |-> (pend_o == '0 && lvl_o == '0 && en_o[0] && !en_o[EDGE_AT_RESET]));

    for (genvar b = 0; b < N_CPU*NIRQ; b++) begin : g_bit
        localparam int C = b / NIRQ;
        localparam int I = b % NIRQ;

        // R4: pending only rises with a level rise or a command
        p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[b]) |-> ($past(cmd_valid_i) || $rose(lvl_o[b])));

        // R3: no level change and no command means no pending change
        p_quiet_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(cmd_valid_i) && $stable(lvl_o[b])) |-> $stable(pend_o[b]));

        // R5: a fall without a command leaves pending alone
        p_fall_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(cmd_valid_i) && $fell(lvl_o[b])) |-> $stable(pend_o[b]));

        // R9: pending only drops through a command
        p_drop_by_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_o[b]) |-> $past(cmd_valid_i));

        // R10: a clear always ends with the bit at 0
        p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_i && cmd_op_i == OP_PEND_CLR && int'(cmd_irq_i) == I
             && (I >= PRIV_PER_CPU || int'(cmd_cpu_i) == C)) |=> !pend_o[b]);
    end
endmodule

bind irq_pend_tracker irq_pend_tracker_chk #(.N_SHARED(N_SHARED), .N_CPU(N_CPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_cpu_i   (cmd_cpu_i),
    .cmd_irq_i   (cmd_irq_i),
    .pend_o      (pend_o),
    .en_o        (en_o),
    .lvl_o       (lvl_o)
);

// File: tb/sim_irq_pend_tracker.sv
module sim_irq_pend_tracker;
    localparam int NS = 32;
    localparam int NC = 2;
    localparam int NIRQ = NS + 32;
    localparam int NLINES = NS + 32*NC;

    localparam int K_PEND = 0;
    localparam int K_EN = 1;
    localparam int K_LVL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NLINES-1:0] lines = '0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [0:0] cmd_cpu = '0;
    logic [5:0] cmd_irq = '0;
    logic [NC-1:0] cmd_arg = '0;
    logic [NC*NIRQ-1:0] pend, en, lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    cpu;
        int    irq;
        logic  exp;
        string tag;
    } item_t;

    item_t exp_q[$];

    always #10 clk = ~clk;

    irq_pend_tracker #(.N_SHARED(NS), .N_CPU(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_cpu_i(cmd_cpu),
        .cmd_irq_i(cmd_irq), .cmd_arg_i(cmd_arg),
        .pend_o(pend), .en_o(en), .lvl_o(lvl)
    );

    // Monitor: drains expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                logic act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_PEND:  act = pend[it.cpu*NIRQ + it.irq];
                    K_EN:    act = en[it.cpu*NIRQ + it.irq];
                    default: act = lvl[it.cpu*NIRQ + it.irq];
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d cpu=%0d irq=%0d actual=%b expected=%b",
                             it.tag, it.kind, it.cpu, it.irq, act, it.exp);
                end
            end
        end
    end

    task automatic expect_bit(input int kind, input int cpu, input int irq,
                              input logic v, input string tag);
        item_t it;
        it.kind = kind; it.cpu = cpu; it.irq = irq; it.exp = v; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic drive_line(input int k, input logic v);
        @(negedge clk);
        lines[k] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_cmd(input int op, input int cpu, input int irq, input int arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 3'(op);
        cmd_cpu = 1'(cpu);
        cmd_irq = 6'(irq);
        cmd_arg = NC'(arg);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        expect_bit(K_PEND, 0, 5, 1'b0, "R8 pend");
        expect_bit(K_EN, 0, 5, 1'b1, "R8 en low irq");
        expect_bit(K_EN, 1, 15, 1'b1, "R8 en irq15");
        expect_bit(K_EN, 0, 16, 1'b0, "R8 en irq16");
        expect_bit(K_EN, 1, 40, 1'b0, "R8 en shared");
        expect_bit(K_LVL, 1, 40, 1'b0, "R8 lvl");

        // Private edge on CPU1 irq3 (line 64+3)
        drive_line(NS + 32 + 3, 1'b1);
        expect_bit(K_PEND, 1, 3, 1'b1, "R4 edge rise pend");
        expect_bit(K_PEND, 0, 3, 1'b0, "R2 other cpu untouched");
        expect_bit(K_LVL, 1, 3, 1'b1, "R2 lvl cpu1");
        drive_line(NS + 32 + 3, 1'b0);
        expect_bit(K_PEND, 1, 3, 1'b1, "R5 fall keeps pend");
        expect_bit(K_LVL, 1, 3, 1'b0, "R5 lvl cleared");
        send_cmd(6, 1, 3, 0);
        expect_bit(K_PEND, 1, 3, 1'b0, "R9 private clear");

        // Shared level irq40 on line 8
        send_cmd(4, 0, 40, 3);
        drive_line(8, 1'b1);
        expect_bit(K_PEND, 0, 40, 1'b0, "R4 level disabled no pend");
        expect_bit(K_PEND, 1, 40, 1'b0, "R4 level disabled no pend");
        expect_bit(K_LVL, 0, 40, 1'b1, "R1 lvl cpu0");
        expect_bit(K_LVL, 1, 40, 1'b1, "R1 lvl cpu1");
        send_cmd(1, 0, 40, 0);
        expect_bit(K_PEND, 0, 40, 1'b1, "R6 enable re-arm cpu0");
        expect_bit(K_PEND, 1, 40, 1'b1, "R6 enable re-arm cpu1");
        send_cmd(6, 0, 40, 0);
        expect_bit(K_PEND, 0, 40, 1'b0, "R9 shared clear cpu0");
        expect_bit(K_PEND, 1, 40, 1'b0, "R9 shared clear cpu1");
        send_cmd(7, 0, 40, 0);
        expect_bit(K_PEND, 0, 40, 1'b1, "R7 complete re-pend");
        expect_bit(K_PEND, 1, 40, 1'b0, "R7 only completing cpu");
        send_cmd(6, 0, 40, 0);
        send_cmd(4, 0, 40, 2);
        send_cmd(7, 0, 40, 0);
        expect_bit(K_PEND, 0, 40, 1'b0, "R7 not in target");
        send_cmd(7, 1, 40, 0);
        expect_bit(K_PEND, 1, 40, 1'b1, "R7 in target");
        drive_line(8, 1'b0);
        expect_bit(K_LVL, 0, 40, 1'b0, "R5 shared lvl cleared");
        expect_bit(K_PEND, 1, 40, 1'b1, "R5 shared fall keeps pend");
        send_cmd(6, 1, 40, 0);
        send_cmd(7, 1, 40, 0);
        expect_bit(K_PEND, 1, 40, 1'b0, "R7 level low no re-pend");
        send_cmd(5, 0, 40, 0);
        expect_bit(K_PEND, 0, 40, 1'b0, "R9 set uses mask cpu0");
        expect_bit(K_PEND, 1, 40, 1'b1, "R9 set uses mask cpu1");

        // Shared edge irq33 on line 1, target CPU0 only
        send_cmd(3, 0, 33, 1);
        send_cmd(4, 0, 33, 1);
        drive_line(1, 1'b1);
        expect_bit(K_PEND, 0, 33, 1'b1, "R1 shared edge target");
        expect_bit(K_PEND, 1, 33, 1'b0, "R1 shared edge non-target");
        send_cmd(6, 0, 33, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        expect_bit(K_PEND, 0, 33, 1'b0, "R3 held level no new event");

        // Private banking, level irq20
        send_cmd(3, 0, 20, 0);
        send_cmd(1, 0, 20, 0);
        expect_bit(K_EN, 0, 20, 1'b1, "R2 enable banked cpu0");
        expect_bit(K_EN, 1, 20, 1'b0, "R2 enable banked cpu1");
        drive_line(NS + 32 + 20, 1'b1);
        expect_bit(K_PEND, 1, 20, 1'b0, "R2 cpu1 disabled level");
        expect_bit(K_LVL, 0, 20, 1'b0, "R2 cpu0 lvl untouched");
        drive_line(NS + 20, 1'b1);
        expect_bit(K_PEND, 0, 20, 1'b1, "R4 enabled level rise");
        send_cmd(1, 1, 20, 0);
        expect_bit(K_PEND, 1, 20, 1'b1, "R6 private enable re-arm");

        // Clear in the same cycle as the rise-driven set (CPU0 irq4, line 36)
        @(negedge clk);
        lines[NS + 4] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_cpu = 1'd0; cmd_irq = 6'd4; cmd_arg = '0;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        expect_bit(K_PEND, 0, 4, 1'b0, "R10 clear beats rise");
        expect_bit(K_LVL, 0, 4, 1'b1, "R10 level still latched");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule